// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a 512-byte, byte-addressed memory reached over a two-wire serial bus. The bus clock and data lines come in as plain inputs and are oversampled on the system clock. The block answers the bus only through an open-drain pull-down enable for the data line. It recognises start and stop conditions and checks the address byte against a fixed device-type nibble and two strap pins. It then carries out sequential writes and reads against an internal register array, with no wait states.

A write transaction has three parts: an address byte with the direction bit clear, a byte that gives the low eight bits of the location, and any number of data bytes. The page bit in the address byte supplies the ninth address bit. A read carries the direction bit set and begins at the currently latched location. A random read is a write of the location followed by a repeated start and a read. A start condition aborts whatever is in progress. A stop condition sends the block back to idle.

Top module: `serial_nvm_slave`

## Requirements
- R1: While reset is asserted and right after it is released, the pull-down enable `sda_oe_o` is low.
- R2: The slave acknowledges an address byte (drives the line low in the ninth clock) only if bits 7..4 equal 1010b and bit 3 equals `sel_hi_i` and bit 2 equals `sel_lo_i`.
- R3: After an address byte that does not match, the slave acknowledges nothing and stores nothing until the next start condition.
- R4: In a write, the byte after the address byte is the low 8 bits of the location, and address-byte bit 1 is bit 8 (the page). Each following data byte is stored at the latched location and acknowledged.
- R5: The 9-bit location increments after each stored or transmitted byte and wraps from 511 to 0.
- R6: In a read (address-byte bit 0 = 1), the slave sends bytes MSB first, starting at the latched location (bit 8 taken from the page bit of the read address byte), and goes on while the master acknowledges each byte.
- R7: When the master leaves the line high after a read byte, the slave releases the line and does not drive it again until the next start condition.
- R8: A start condition in the middle of a byte discards the partial byte, leaves the location unchanged and makes the next byte an address byte.
- R9: A stop condition in the middle of a byte discards the partial byte, releases the line and returns the slave to idle.
- R10: `sda_oe_o` changes only after a detected falling edge of SCL (or on start or stop), never while SCL is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_hi_i | input | 1 | Strap pin compared with address-byte bit 3 |
| sel_lo_i | input | 1 | Strap pin compared with address-byte bit 2 |
| sda_oe_o | output | 1 | High pulls the data line low; the line is never driven high |

## Verification
The assertions check on every cycle that the pull-down enable moves only after a clock falling edge or a bus condition, that a stop leaves the block idle and released, and that a start re-arms address reception. They also check that a mismatched or ended transaction keeps the line released, that a rejected address byte gets no acknowledge, and that each stored byte advances the location by one. The bench scenarios show what depends on the byte stream as a whole. They sweep every pin strap against every select code, fill a region that runs across the 511-to-0 wrap, and read it back. They also show that an aborted partial byte never reaches memory, and that page selection and current-location reads land on the expected cells.

// File: rtl/snvm_pkg.sv
package snvm_pkg;
  localparam int BYTE_W = 8;
  localparam int MEM_AW = BYTE_W + 1;
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_SACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } slv_state_t;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WORD,
    RX_DATA
  } rx_kind_t;
endpackage

// File: rtl/snvm_line_sync.sv
module snvm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/snvm_byte_store.sv
module snvm_byte_store
  import snvm_pkg::*;
(
  input  logic              clk,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] cells [MEM_DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[addr_i] <= wdata_i;
  end

  assign rdata_o = cells[addr_i];
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
  import snvm_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sel_hi_i,
  input  logic sel_lo_i,
  output logic sda_oe_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic bus_start, bus_stop;

  snvm_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );
  snvm_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign bus_start = scl_lvl & ~scl_rise & sda_fall;
  assign bus_stop  = scl_lvl & ~scl_rise & sda_rise;

  slv_state_t        state_q, state_d;
  rx_kind_t          kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic              mack_q, mack_d;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_rdata;
  logic              dev_match;

  snvm_byte_store u_store (
    .clk(clk), .we_i(mem_we), .addr_i(addr_q),
    .wdata_i(sh_q), .rdata_o(mem_rdata)
  );

  assign dev_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3] == sel_hi_i) && (sh_q[2] == sel_lo_i);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    addr_d  = addr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    mem_we  = 1'b0;
    if (bus_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      cnt_d   = '0;
    end else if (bus_start) begin
      state_d = ST_RX;
      kind_d  = RX_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == LAST_BIT) begin
            cnt_d = '0;
            case (kind_q)
              RX_DEV: begin
                if (dev_match) begin
                  addr_d[MEM_AW-1] = sh_q[1];
                  rw_d    = sh_q[0];
                  oe_d    = 1'b1;
                  state_d = ST_SACK;
                end else begin
                  state_d = ST_IGNORE;
                end
              end
              RX_WORD: begin
                addr_d  = {addr_q[MEM_AW-1], sh_q};
                oe_d    = 1'b1;
                state_d = ST_SACK;
              end
              default: begin
                mem_we  = 1'b1;
                addr_d  = addr_q + 1'b1;
                oe_d    = 1'b1;
                state_d = ST_SACK;
              end
            endcase
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            if (kind_q == RX_DEV && rw_q) begin
              tx_d    = mem_rdata;
              oe_d    = ~mem_rdata[BYTE_W-1];
              addr_d  = addr_q + 1'b1;
              state_d = ST_TX;
            end else begin
              kind_d  = (kind_q == RX_DEV) ? RX_WORD : RX_DATA;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_d = cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              cnt_d   = '0;
              state_d = ST_MACK;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
              oe_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              tx_d    = mem_rdata;
              oe_d    = ~mem_rdata[BYTE_W-1];
              addr_d  = addr_q + 1'b1;
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_IDLE, ST_IGNORE: ;
        default: begin
          state_d = ST_IDLE;
          oe_d    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= RX_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe_o = oe_q;

  // The pull-down only moves after an SCL fall or a bus condition
  assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> $past(scl_fall | bus_start | bus_stop));

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (state_q == ST_IDLE && !oe_q && cnt_q == '0));

  assert_start_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !bus_stop) |=> (state_q == ST_RX && kind_q == RX_DEV && cnt_q == '0));

  // Covers R7 as well: after a master NACK the block sits here released
  assert_quiet_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !oe_q);

  assert_no_ack_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RX && kind_q == RX_DEV && scl_fall && cnt_q == LAST_BIT &&
     !bus_start && !bus_stop &&
     (sh_q[7:4] != DEV_TYPE || sh_q[3] != sel_hi_i || sh_q[2] != sel_lo_i)) |=> !oe_q);

  assert_store_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: tb/serial_nvm_slave_bench.sv
module serial_nvm_slave_bench;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sel_hi = 1'b1;
  logic sel_lo = 1'b0;
  logic sda_oe;
  logic sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  int hi_changes = 0;
  bit done = 1'b0;
  logic [7:0] model [512];

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  serial_nvm_slave u_serial_nvm_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sel_hi_i(sel_hi), .sel_lo_i(sel_lo), .sda_oe_o(sda_oe)
  );

  // R10 monitor: the enable must not move while SCL stays high
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) hi_changes++;
    prev_scl = scl_m;
    prev_oe  = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0;
  endtask

  task automatic bstop();
    qw(); sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic tx_bit(input logic b);
    qw(); sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0;
  endtask

  task automatic rx_bit(output logic b);
    qw(); sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) tx_bit(d[i]);
    rx_bit(b);
    ack = ~b;
  endtask

  task automatic rx_byte(output logic [7:0] d, input bit ack);
    for (int i = 7; i >= 0; i--) rx_bit(d[i]);
    tx_bit(~ack);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] devb(input bit page, input bit rd);
    return {4'b1010, sel_hi, sel_lo, page, rd};
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // start, address byte, word byte, repeated start, read address byte
  task automatic seek_read(input bit page, input logic [7:0] lo);
    bit a;
    bstart(); tx_byte(devb(page, 1'b0), a); chk(a, "R4 addr ack", a, 1);
    tx_byte(lo, a); chk(a, "R4 word ack", a, 1);
    bstart(); tx_byte(devb(page, 1'b1), a); chk(a, "R6 read addr ack", a, 1);
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    int base;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 after reset", sda_oe, 0);

    // R2 sweep: every strap setting against every select code
    for (int ps = 0; ps < 4; ps++) begin
      sel_hi = ps[1]; sel_lo = ps[0];
      for (int ac = 0; ac < 4; ac++) begin
        bstart(); tx_byte(8'hA0 | 8'(ac << 2), a); bstop();
        chk(a == (ac == ps), "R2 select match", a, int'(ac == ps));
      end
      bstart(); tx_byte(8'hB0 | 8'(ps << 2), a); bstop();
      chk(a == 1'b0, "R2 wrong type", a, 0);
    end
    sel_hi = 1'b1; sel_lo = 1'b0;

    // R4/R5: fill 256 bytes from 0x180 across the 511->0 wrap
    base = 9'h180;
    bstart(); tx_byte(devb(1'b1, 1'b0), a); chk(a, "R4 addr ack", a, 1);
    tx_byte(8'h80, a); chk(a, "R4 word ack", a, 1);
    for (int i = 0; i < 256; i++) begin
      tx_byte(pat(i), a);
      chk(a, "R4 data ack", a, 1);
      model[(base + i) % 512] = pat(i);
    end
    bstop();

    // R6/R5: read back the whole region through the wrap
    seek_read(1'b1, 8'h80);
    for (int i = 0; i < 256; i++) begin
      rx_byte(d, i != 255);
      chk(d == model[(base + i) % 512], "R5 R6 read wrap", d, model[(base + i) % 512]);
    end
    bstop();
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);

    // R6 current location read, then R7 release after NACK
    bstart(); tx_byte(devb(1'b0, 1'b0), a); tx_byte(8'h7E, a); bstop();
    bstart(); tx_byte(devb(1'b0, 1'b1), a); chk(a, "R6 current ack", a, 1);
    rx_byte(d, 1'b1); chk(d == model[9'h07E], "R6 current first", d, model[9'h07E]);
    rx_byte(d, 1'b0); chk(d == model[9'h07F], "R6 current second", d, model[9'h07F]);
    rx_byte(d, 1'b0); chk(d == 8'hFF, "R7 no drive after nack", d, 8'hFF);
    bstop();

    // R8: start mid data byte discards it and keeps the location
    bstart(); tx_byte(devb(1'b0, 1'b0), a); tx_byte(8'h10, a);
    for (int i = 0; i < 4; i++) tx_bit(i[0]);
    bstart(); tx_byte(devb(1'b0, 1'b1), a); chk(a, "R8 readdress ack", a, 1);
    rx_byte(d, 1'b0); chk(d == model[9'h010], "R8 partial dropped", d, model[9'h010]);
    bstop();

    // R9: stop mid data byte discards it
    bstart(); tx_byte(devb(1'b0, 1'b0), a); tx_byte(8'h20, a);
    for (int i = 0; i < 5; i++) tx_bit(1'b0);
    bstop();
    chk(sda_oe == 1'b0, "R9 idle after stop", sda_oe, 0);
    seek_read(1'b0, 8'h20);
    rx_byte(d, 1'b0); chk(d == model[9'h020], "R9 partial dropped", d, model[9'h020]);
    bstop();

    // R3: mismatched address, following bytes ignored
    bstart(); tx_byte(8'hA0, a); chk(a == 1'b0, "R3 mismatch nack", a, 0);
    tx_byte(8'h20, a); chk(a == 1'b0, "R3 word ignored", a, 0);
    tx_byte(8'hEE, a); chk(a == 1'b0, "R3 data ignored", a, 0);
    bstop();
    seek_read(1'b0, 8'h20);
    rx_byte(d, 1'b0); chk(d == model[9'h020], "R3 memory untouched", d, model[9'h020]);
    bstop();

    // R4 page bit: same low byte on both pages
    bstart(); tx_byte(devb(1'b0, 1'b0), a); tx_byte(8'h05, a); tx_byte(8'h3C, a); bstop();
    bstart(); tx_byte(devb(1'b1, 1'b0), a); tx_byte(8'h05, a); tx_byte(8'hC3, a); bstop();
    seek_read(1'b0, 8'h05);
    rx_byte(d, 1'b0); chk(d == 8'h3C, "R4 page 0", d, 8'h3C);
    bstop();
    seek_read(1'b1, 8'h05);
    rx_byte(d, 1'b0); chk(d == 8'hC3, "R4 page 1", d, 8'hC3);
    bstop();

    chk(hi_changes == 0, "R10 stable while SCL high", hi_changes, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule